// File: doc/BRIEF.md
# Multi-Waveform Direct Digital Synthesis Generator

This block is a direct digital synthesis core. A 32-bit phase accumulator advances by a frequency tuning word each time a sample strobe arrives. The output frequency is therefore the tuning word times the strobe rate, divided by 2^32. At a 96 kHz strobe rate one tuning step is worth about 22.35 µHz. The accumulated phase is shaped into one of four waveforms: sine, square, triangle or sawtooth. The result is a signed 16-bit sample. An 8-bit offset-binary copy of that sample is also provided for a parallel resistor-ladder DAC.

The sine is drawn from a quarter-wave table of 256 entries that is computed during elaboration. The two top phase bits pick the quadrant: the table index is mirrored in odd quadrants, and the value is negated in the second half-cycle. An optional mode takes the two adjacent full-wave entries and blends them linearly, using the phase bits below the table index. This gives finer amplitude steps.

The tuning word, the waveform select and the interpolation switch are captured only when a strobe is present. A change on those inputs therefore never affects a sample that is already in flight.

Top module: `dds_wavegen`

## Requirements
- R1: A synchronous active-low reset clears the accumulator, drops `valid_o` and sets `sample_o` to 0 (`dac_o` reads 8'h80). The first sample after reset uses phase 0.
- R2: Every strobe produces a sample from the accumulator value held before that strobe. The accumulator then becomes (accumulator + tuning word) mod 2^32, so any tuning word wraps with no saturation.
- R3: In cycles without a strobe, the tuning word, select and interpolation inputs are ignored. The accumulator holds its value and no `valid_o` pulse appears.
- R4: Call the rising edge that samples a strobe edge 1. After edge 2, `sample_o` carries the new sample and `valid_o` is high for exactly one cycle for each strobe. Back-to-back strobes are accepted.
- R5: The select encoding is 0 = sine, 1 = square, 2 = triangle, 3 = sawtooth. It is captured with the strobe and applies to that strobe's sample.
- R6: Square gives 16'h7FFF when phase bit 31 is 0 and 16'h8000 when it is 1.
- R7: Sawtooth gives phase bits [31:16] read as a signed value.
- R8: Triangle takes phase bits [30:15], inverts them when phase bit 31 is 1, and then flips the top bit of the result. The output runs from -32768 at phase 0 up to +32767 near mid-cycle and back down.
- R9: Sine (interpolation off) uses full index p = phase[31:22], with j = p[7:0] and table entry T[i] = round(32767·sin(2π(i+0.5)/1024)). The index is 255−j when p[8] is 1 and j otherwise. The value is negated when p[9] is 1.
- R10: With interpolation on, sine = s0 + floor((s1−s0)·f / 256). Here s0 is the sine of index p, s1 is the sine of (p+1) mod 1024, and f = phase[21:14].
- R11: `dac_o` equals `sample_o[15:8]` with its top bit inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| strobe_i | input | 1 | Sample strobe; advances phase and starts one sample |
| tune_word_i | input | 32 | Frequency tuning word |
| wave_sel_i | input | 2 | Waveform select: 0 sine, 1 square, 2 triangle, 3 sawtooth |
| interp_en_i | input | 1 | Enables linear interpolation for the sine |
| sample_o | output | 16 | Signed output sample |
| dac_o | output | 8 | Offset-binary upper byte for a parallel DAC |
| valid_o | output | 1 | One-cycle pulse marking a new sample |

## Verification
The sine is driven with a tuning word that is not a multiple of the table step, so every quadrant and a wide spread of fractional phases appear. This separates mirroring and negation faults from interpolation faults, and the same word is run with and without blending. Square, triangle and sawtooth each use their own tuning word. A run that switches the select on every back-to-back strobe shows whether the select is captured per sample. A tuning word near 2^32 tests the modulo wrap. Idle stretches, during which the inputs are changed without a strobe, confirm that the accumulator ignores them. A reset in mid-run checks that the sequence restarts from phase zero.

// File: rtl/dds_pkg.sv
// Shared types for the DDS waveform generator.
// Assumes a 2-bit waveform select with a fixed encoding.
package dds_pkg;
    typedef enum logic [1:0] {
        WAVE_SINE   = 2'd0,
        WAVE_SQUARE = 2'd1,
        WAVE_TRI    = 2'd2,
        WAVE_SAW    = 2'd3
    } wave_t;
endpackage

// File: rtl/dds_phase_acc.sv
// Phase accumulator and strobe capture stage.
// On each strobe it hands the current phase and the captured controls
// to the next stage, then adds the tuning word modulo 2^PHASE_W.
// Assumes inputs are synchronous to clk.
module dds_phase_acc
    import dds_pkg::*;
#(
    parameter int PHASE_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               strobe_i,
    input  logic [PHASE_W-1:0] tune_i,
    input  wave_t              sel_i,
    input  logic               interp_i,
    output logic [PHASE_W-1:0] phase_o,
    output wave_t              sel_o,
    output logic               interp_o,
    output logic               vld_o
);
    logic [PHASE_W-1:0] acc_q;

    // Advance the accumulator only when a strobe is present.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (strobe_i) begin
            acc_q <= acc_q + tune_i;
        end
    end

    // Capture phase and controls for the shaping stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_o  <= '0;
            sel_o    <= WAVE_SINE;
            interp_o <= 1'b0;
            vld_o    <= 1'b0;
        end else begin
            vld_o <= strobe_i;
            if (strobe_i) begin
                phase_o  <= acc_q;
                sel_o    <= sel_i;
                interp_o <= interp_i;
            end
        end
    end

    AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_i |=> $stable(acc_q)); // R3
endmodule

// File: rtl/dds_sine_lut.sv
// Full-wave sine lookup built on a quarter-wave table.
// The table is computed at elaboration with half-step offsets so that
// mirroring by bit inversion is exact. Assumes ABITS >= 1.
module dds_sine_lut #(
    parameter int ABITS = 8,
    parameter int OUT_W = 16
) (
    input  logic [ABITS+1:0]        p_i,
    output logic signed [OUT_W-1:0] s_o
);
    localparam int  DEPTH = 1 << ABITS;
    localparam int  TAB_W = DEPTH * OUT_W;
    localparam real PI    = 3.14159265358979;
    localparam real AMP   = real'((1 << (OUT_W - 1)) - 1);

    function automatic logic [TAB_W-1:0] build_table();
        logic [TAB_W-1:0] t;
        real a;
        int  v;
        t = '0;
        for (int i = 0; i < DEPTH; i++) begin
            a = AMP * $sin(2.0 * PI * (real'(i) + 0.5) / real'(4 * DEPTH));
            v = $rtoi(a + 0.5);
            t[i*OUT_W +: OUT_W] = OUT_W'(v);
        end
        return t;
    endfunction

    localparam logic [TAB_W-1:0] TABLE = build_table();

    logic [1:0]       quad;
    logic [ABITS-1:0] idx;
    logic [OUT_W-1:0] mag;

    // Mirror the index in odd quadrants, negate in the second half-cycle.
    always_comb begin
        quad = p_i[ABITS+1 -: 2];
        idx  = quad[0] ? ~p_i[ABITS-1:0] : p_i[ABITS-1:0];
        mag  = TABLE[idx*OUT_W +: OUT_W];
        s_o  = quad[1] ? -$signed(mag) : $signed(mag);
    end
endmodule

// File: rtl/dds_shaper.sv
// Combinational waveform shaper: turns a phase into a signed sample
// for the selected waveform. Two lookups give adjacent sine points
// for optional linear interpolation. Assumes PHASE_W >= OUT_W + 1.
module dds_shaper
    import dds_pkg::*;
#(
    parameter int PHASE_W = 32,
    parameter int OUT_W   = 16,
    parameter int ABITS   = 8,
    parameter int FRAC_W  = 8
) (
    input  logic [PHASE_W-1:0]      phase_i,
    input  wave_t                   sel_i,
    input  logic                    interp_i,
    output logic signed [OUT_W-1:0] sample_o
);
    localparam int IDX_W  = ABITS + 2;
    localparam int PROD_W = OUT_W + FRAC_W + 2;
    localparam logic [OUT_W-1:0] POS_MAX = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] NEG_MIN = {1'b1, {(OUT_W-1){1'b0}}};

    logic [IDX_W-1:0]        p_idx [2];
    logic signed [OUT_W-1:0] s_pt  [2];

    assign p_idx[0] = phase_i[PHASE_W-1 -: IDX_W];
    assign p_idx[1] = phase_i[PHASE_W-1 -: IDX_W] + IDX_W'(1);

    for (genvar k = 0; k < 2; k++) begin : g_lut
        dds_sine_lut #(.ABITS(ABITS), .OUT_W(OUT_W)) u_lut (
            .p_i (p_idx[k]),
            .s_o (s_pt[k])
        );
    end

    logic [FRAC_W-1:0]        frac;
    logic signed [OUT_W:0]    s_diff;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] step;
    logic [OUT_W-1:0]         sine_v;
    logic [OUT_W-1:0]         fold;

    // Blend two adjacent sine points by the sub-index phase fraction.
    always_comb begin
        frac   = phase_i[PHASE_W-IDX_W-1 -: FRAC_W];
        s_diff = {s_pt[1][OUT_W-1], s_pt[1]} - {s_pt[0][OUT_W-1], s_pt[0]};
        prod   = $signed({{(FRAC_W+1){s_diff[OUT_W]}}, s_diff})
               * $signed({{(OUT_W+1){1'b0}}, 1'b0, frac});
        step   = prod >>> FRAC_W;
        sine_v = interp_i ? (s_pt[0] + step[OUT_W-1:0]) : s_pt[0];
    end

    // Fold the phase for the triangle.
    always_comb begin
        fold = phase_i[PHASE_W-1] ? ~phase_i[PHASE_W-2 -: OUT_W]
                                  :  phase_i[PHASE_W-2 -: OUT_W];
    end

    // Pick the waveform.
    always_comb begin
        unique case (sel_i)
            WAVE_SINE:   sample_o = sine_v;
            WAVE_SQUARE: sample_o = phase_i[PHASE_W-1] ? NEG_MIN : POS_MAX;
            WAVE_TRI:    sample_o = {~fold[OUT_W-1], fold[OUT_W-2:0]};
            default:     sample_o = phase_i[PHASE_W-1 -: OUT_W];
        endcase
    end
endmodule

// File: rtl/dds_wavegen.sv
// Top of the DDS waveform generator. A strobe is captured by the
// phase stage; the shaped sample is registered one edge later.
// The DAC byte is the upper sample byte in offset binary.
// Assumes strobes are single-clock-synchronous pulses or levels.
module dds_wavegen
    import dds_pkg::*;
#(
    parameter int PHASE_W = 32,
    parameter int OUT_W   = 16,
    parameter int ABITS   = 8,
    parameter int FRAC_W  = 8,
    parameter int DAC_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               strobe_i,
    input  logic [PHASE_W-1:0] tune_word_i,
    input  logic [1:0]         wave_sel_i,
    input  logic               interp_en_i,
    output logic [OUT_W-1:0]   sample_o,
    output logic [DAC_W-1:0]   dac_o,
    output logic               valid_o
);
    localparam logic [DAC_W-1:0] DAC_OFS = {1'b1, {(DAC_W-1){1'b0}}};

    logic [PHASE_W-1:0]      phase_s;
    wave_t                   sel_s;
    logic                    interp_s;
    logic                    vld_s;
    logic signed [OUT_W-1:0] shaped;
    logic [OUT_W-1:0]        sample_q;
    logic                    valid_q;

    dds_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (strobe_i),
        .tune_i   (tune_word_i),
        .sel_i    (wave_t'(wave_sel_i)),
        .interp_i (interp_en_i),
        .phase_o  (phase_s),
        .sel_o    (sel_s),
        .interp_o (interp_s),
        .vld_o    (vld_s)
    );

    dds_shaper #(
        .PHASE_W (PHASE_W),
        .OUT_W   (OUT_W),
        .ABITS   (ABITS),
        .FRAC_W  (FRAC_W)
    ) u_shape (
        .phase_i  (phase_s),
        .sel_i    (sel_s),
        .interp_i (interp_s),
        .sample_o (shaped)
    );

    // Register the shaped sample and the valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_q <= '0;
            valid_q  <= 1'b0;
        end else begin
            valid_q <= vld_s;
            if (vld_s) begin
                sample_q <= shaped;
            end
        end
    end

    assign sample_o = sample_q;
    assign valid_o  = valid_q;
    assign dac_o    = sample_q[OUT_W-1 -: DAC_W] ^ DAC_OFS;

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_i |-> ##2 valid_o); // R4
    AST_VALID_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(vld_s)); // R4
    AST_SQUARE_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_s && sel_s == WAVE_SQUARE) |=>
        (sample_o == {1'b0, {(OUT_W-1){1'b1}}} ||
         sample_o == {1'b1, {(OUT_W-1){1'b0}}})); // R6
    AST_SINE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_s && sel_s == WAVE_SINE) |=>
        sample_o != {1'b1, {(OUT_W-1){1'b0}}}); // R9
endmodule

// File: tb/sim_dds_wavegen.sv
module sim_dds_wavegen;
    localparam time CLK_HALF = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strobe_i = 1'b0;
    logic [31:0] tune_word_i = '0;
    logic [1:0]  wave_sel_i = '0;
    logic        interp_en_i = 1'b0;
    logic [15:0] sample_o;
    logic [7:0]  dac_o;
    logic        valid_o;

    dds_wavegen u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .strobe_i    (strobe_i),
        .tune_word_i (tune_word_i),
        .wave_sel_i  (wave_sel_i),
        .interp_en_i (interp_en_i),
        .sample_o    (sample_o),
        .dac_o       (dac_o),
        .valid_o     (valid_o)
    );

    always #CLK_HALF clk = ~clk;

    typedef struct {
        logic [15:0] s;
        int          cyc;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          checks = 0;
    int          fails = 0;
    int          cyc = 0;
    logic [31:0] m_phase = '0;
    int          tab[256];
    bit          done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        for (int i = 0; i < 256; i++)
            tab[i] = $rtoi(32767.0 * $sin(2.0 * 3.14159265358979 * (real'(i) + 0.5) / 1024.0) + 0.5);
    end

    function automatic int sine_at(int p);
        int j, v;
        j = p & 255;
        v = ((p >> 8) & 1) ? tab[255 - j] : tab[j];
        return ((p >> 9) & 1) ? -v : v;
    endfunction

    function automatic logic [15:0] model(logic [31:0] ph, logic [1:0] sel, logic ip);
        int p, s0, s1, f;
        logic [15:0] fo;
        case (sel)
            2'd0: begin
                p  = int'(ph[31:22]);
                s0 = sine_at(p);
                s1 = sine_at((p + 1) & 1023);
                f  = int'(ph[21:14]);
                return ip ? 16'(s0 + (((s1 - s0) * f) >>> 8)) : 16'(s0);
            end
            2'd1: return ph[31] ? 16'h8000 : 16'h7FFF;
            2'd2: begin
                fo = ph[31] ? ~ph[30:15] : ph[30:15];
                return fo ^ 16'h8000;
            end
            default: return ph[31:16];
        endcase
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    // Driver: one strobe, expected item pushed to the scoreboard.
    task automatic send(logic [31:0] tw, logic [1:0] sel, logic ip, string tag, int gap);
        exp_t e;
        @(negedge clk);
        strobe_i    = 1'b1;
        tune_word_i = tw;
        wave_sel_i  = sel;
        interp_en_i = ip;
        e.s   = model(m_phase, sel, ip);
        e.cyc = cyc + 2;
        e.tag = tag;
        sb.push_back(e);
        m_phase = m_phase + tw;
        if (gap > 0) begin
            @(negedge clk);
            strobe_i = 1'b0;
            repeat (gap - 1) @(negedge clk);
        end
    endtask

    task automatic idle(int n);
        @(negedge clk);
        strobe_i = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pop and compare as samples appear.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (valid_o) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R3 R4", "unexpected valid", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(cyc == e.cyc, "R4", "valid cycle", cyc, e.cyc);
                    check(sample_o == e.s, e.tag, "sample", sample_o, e.s);
                    check(dac_o == (e.s[15:8] ^ 8'h80), "R11", "dac", dac_o, e.s[15:8] ^ 8'h80);
                end
            end else if (sb.size() > 0 && cyc > sb[0].cyc) begin
                check(1'b0, "R4", "missing valid", 0, 1);
                void'(sb.pop_front());
            end
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_HALF * 2 * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(valid_o == 1'b0, "R1", "valid after reset", valid_o, 0);
        check(sample_o == 16'h0000, "R1", "sample after reset", sample_o, 0);
        check(dac_o == 8'h80, "R1", "dac after reset", dac_o, 8'h80);

        // R1 R2: first sample from phase zero, saw shows raw phase
        send(32'h1234_5678, 2'd3, 1'b0, "R1 R7", 2);
        for (int i = 0; i < 40; i++) send(32'h0765_4321, 2'd3, 1'b0, "R2 R7", 1);
        // R9: sine, all quadrants, spaced strobes
        for (int i = 0; i < 300; i++) send(32'h0123_4567, 2'd0, 1'b0, "R9", 3);
        // R10: same word, interpolated, back-to-back
        for (int i = 0; i < 300; i++) send(32'h0123_4567, 2'd0, 1'b1, "R10", 0);
        idle(4);
        // R6 square
        for (int i = 0; i < 40; i++) send(32'h1900_0000, 2'd1, 1'b0, "R6", 1);
        // R8 triangle
        for (int i = 0; i < 40; i++) send(32'h0B00_1234, 2'd2, 1'b0, "R8", 0);
        idle(3);
        // R3: change inputs without strobe; accumulator must not move
        tune_word_i = 32'h7777_7777;
        wave_sel_i  = 2'd1;
        interp_en_i = 1'b1;
        repeat (20) @(negedge clk);
        send(32'h0000_0100, 2'd3, 1'b0, "R3", 2);
        // R5: select switched on every strobe
        for (int i = 0; i < 32; i++) send(32'h0A3D_70A4, 2'(i), i[2], "R5", 0);
        idle(3);
        // R2: wrap with a tuning word near 2^32
        for (int i = 0; i < 40; i++) send(32'hFFFF_FFF0 - 32'(i * 32'h0100_0000), 2'd3, 1'b0, "R2", 0);
        for (int i = 0; i < 20; i++) send(32'hF000_0001, 2'd0, 1'b1, "R2 R10", 0);
        idle(6);
        // R1: reset in mid-run restarts at phase zero
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_phase = '0;
        check(valid_o == 1'b0, "R1", "valid after second reset", valid_o, 0);
        send(32'h0400_0000, 2'd0, 1'b0, "R1 R9", 0);
        for (int i = 0; i < 10; i++) send(32'h0400_0000, 2'd2, 1'b0, "R1 R8", 0);
        idle(6);
        check(sb.size() == 0, "R4", "scoreboard drained", sb.size(), 0);
        finish_run();
    end
endmodule